// File: doc/BRIEF.md
# Translated-Address Cache Hit and Way Select

This block resolves, once per clock, whether a request hits in a 4-way set-associative cache whose directory holds absolute (physical) tags. The request presents a logical page tag. The block compares that tag against the entries of a small logical TLB row. The matching entry picks the absolute page stored beside it in the absolute TLB. That absolute page is then compared against the tag of every directory way at the same time. The surrounding arrays are read outside the block, and their rows for the indexed set arrive on the input ports in the same cycle as the request.

The comparison, the combining with the TLB result and the steering of the data all happen in one combinational pass. The verdict is captured into registers at the next rising edge. The captured hit flag, one-hot way vector and error flag cover exactly one cycle. Each edge reloads them, so a cycle without a request clears them, which gives the same reset-every-cycle behaviour as a precharged hit path. The data register loads only on a hit.

Top module: `cache_hit_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `hit`, `hit_way`, `multi_hit` and `data_out` become all zero.
- R2: `hit` is 1 in the cycle after a request (`req_valid`=1) exactly when some valid logical TLB entry equals `req_vtag` and the chosen absolute page equals the tag of at least one valid directory way.
- R3: When `hit` is 1, `hit_way` has exactly one bit set, and bit i stands for way i. When `hit` is 0, `hit_way` is zero.
- R4: On a hit, `data_out` holds the word of the selected way, taken from `way_data` bits [i*DATA_W +: DATA_W] for way i.
- R5: On a miss, `hit` is 0 and `data_out` keeps its previous value.
- R6: A TLB entry whose bit in `ltlb_valid` is 0, or a directory way whose bit in `dir_valid` is 0, never takes part in a match.
- R7: When two or more ways match, `multi_hit` is 1 and the lowest-numbered matching way is selected. `multi_hit` is never 1 without `hit`.
- R8: When two or more TLB entries match `req_vtag`, the absolute page of the lowest-numbered matching entry is the one compared with the directory.
- R9: A hit lasts one cycle only. If the next cycle carries no request, `hit` returns to 0.
- R10: A cycle with `req_valid`=0 yields `hit`=0 and `multi_hit`=0, whatever the array inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A lookup is requested this cycle |
| req_vtag | input | VTAG_W | Logical page tag of the request |
| ltlb_valid | input | TLB_N | Valid bit per logical TLB entry of the row |
| ltlb_vtag | input | TLB_N*VTAG_W | Logical tags of the row, entry i at [i*VTAG_W +: VTAG_W] |
| atlb_page | input | TLB_N*ATAG_W | Absolute page paired with each entry, entry i at [i*ATAG_W +: ATAG_W] |
| dir_valid | input | WAYS | Valid bit per directory way |
| dir_tag | input | WAYS*ATAG_W | Absolute tag per way, way i at [i*ATAG_W +: ATAG_W] |
| way_data | input | WAYS*DATA_W | Data word of each way for the indexed set |
| hit | output | 1 | Registered hit verdict |
| hit_way | output | WAYS | Registered one-hot selected way |
| multi_hit | output | 1 | Registered flag: more than one way matched |
| data_out | output | DATA_W | Cache output register |

## Verification
The assertions check on every cycle the properties that depend only on the shape of the result. The way vector is one-hot on a hit and clear on a miss. The error flag appears only with a hit. An idle cycle produces no hit. The data register holds across a miss. The chosen way is the lowest one that matched, and no invalid way ever matches. Whether the translation picked the right absolute page, and whether the right word was captured, can only be shown by the bench's reference model. That model looks up the loaded register files by its own method, and directed cases cover TLB aliasing, cleared valid bits, tag collisions across ways and a hit followed by an idle cycle.

// File: rtl/chu_pkg.sv
package chu_pkg;
  localparam int unsigned VEC_MAX = 32;

  // isolate the lowest set bit of a vector (lowest index wins)
  function automatic logic [VEC_MAX-1:0] pick_lowest(input logic [VEC_MAX-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // true when more than one bit is set
  function automatic logic several_set(input logic [VEC_MAX-1:0] v);
    return (v & (v - 1'b1)) != '0;
  endfunction
endpackage

// File: rtl/chu_tlb_match.sv
module chu_tlb_match
  import chu_pkg::*;
#(
  parameter int unsigned TLB_N  = 2,
  parameter int unsigned VTAG_W = 8,
  parameter int unsigned ATAG_W = 10
) (
  input  logic [VTAG_W-1:0]       req_vtag,
  input  logic [TLB_N-1:0]        ltlb_valid,
  input  logic [TLB_N*VTAG_W-1:0] ltlb_vtag,
  input  logic [TLB_N*ATAG_W-1:0] atlb_page,
  output logic                    tlb_hit,
  output logic [ATAG_W-1:0]       abs_tag
);
  logic [TLB_N-1:0] ent_match;
  logic [TLB_N-1:0] ent_sel;

  for (genvar e = 0; e < TLB_N; e++) begin : g_ent
    assign ent_match[e] = ltlb_valid[e] && (ltlb_vtag[e*VTAG_W +: VTAG_W] == req_vtag);
  end

  always_comb begin
    logic [VEC_MAX-1:0] wide;
    wide    = VEC_MAX'(ent_match);
    ent_sel = TLB_N'(pick_lowest(wide));
    tlb_hit = |ent_match;
    abs_tag = '0;
    for (int e = 0; e < TLB_N; e++) begin
      abs_tag |= atlb_page[e*ATAG_W +: ATAG_W] & {ATAG_W{ent_sel[e]}};
    end
  end
endmodule

// File: rtl/chu_dir_compare.sv
module chu_dir_compare #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned ATAG_W = 10
) (
  input  logic                   lookup_en,
  input  logic [ATAG_W-1:0]      abs_tag,
  input  logic [WAYS-1:0]        dir_valid,
  input  logic [WAYS*ATAG_W-1:0] dir_tag,
  output logic [WAYS-1:0]        way_match
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic tag_eq;
    assign tag_eq       = (dir_tag[w*ATAG_W +: ATAG_W] == abs_tag);
    assign way_match[w] = lookup_en && dir_valid[w] && tag_eq;
  end
endmodule

// File: rtl/chu_way_select.sv
module chu_way_select
  import chu_pkg::*;
#(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic [WAYS-1:0]        way_match,
  input  logic [WAYS*DATA_W-1:0] way_data,
  output logic [WAYS-1:0]        sel_onehot,
  output logic                   any_hit,
  output logic                   multi,
  output logic [DATA_W-1:0]      sel_data
);
  always_comb begin
    logic [VEC_MAX-1:0] wide;
    wide       = VEC_MAX'(way_match);
    sel_onehot = WAYS'(pick_lowest(wide));
    any_hit    = |way_match;
    multi      = several_set(wide);
    sel_data   = '0;
    for (int w = 0; w < WAYS; w++) begin
      sel_data |= way_data[w*DATA_W +: DATA_W] & {DATA_W{sel_onehot[w]}};
    end
  end
endmodule

// File: rtl/cache_hit_unit.sv
module cache_hit_unit #(
  parameter int unsigned TLB_N  = 2,
  parameter int unsigned VTAG_W = 8,
  parameter int unsigned ATAG_W = 10,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [VTAG_W-1:0]       req_vtag,
  input  logic [TLB_N-1:0]        ltlb_valid,
  input  logic [TLB_N*VTAG_W-1:0] ltlb_vtag,
  input  logic [TLB_N*ATAG_W-1:0] atlb_page,
  input  logic [WAYS-1:0]         dir_valid,
  input  logic [WAYS*ATAG_W-1:0]  dir_tag,
  input  logic [WAYS*DATA_W-1:0]  way_data,
  output logic                    hit,
  output logic [WAYS-1:0]         hit_way,
  output logic                    multi_hit,
  output logic [DATA_W-1:0]       data_out
);
  // internal events brought out for checking
  logic              tlb_hit;
  logic [ATAG_W-1:0] abs_tag;
  logic              lookup_en;
  logic [WAYS-1:0]   way_match;
  logic [WAYS-1:0]   sel_onehot;
  logic              lookup_hit;
  logic              lookup_multi;
  logic [DATA_W-1:0] sel_data;

  logic              hit_q;
  logic [WAYS-1:0]   way_q;
  logic              err_q;
  logic [DATA_W-1:0] data_q;

  chu_tlb_match #(.TLB_N(TLB_N), .VTAG_W(VTAG_W), .ATAG_W(ATAG_W)) u_tlb (
    .req_vtag  (req_vtag),
    .ltlb_valid(ltlb_valid),
    .ltlb_vtag (ltlb_vtag),
    .atlb_page (atlb_page),
    .tlb_hit   (tlb_hit),
    .abs_tag   (abs_tag)
  );

  assign lookup_en = req_valid && tlb_hit;

  chu_dir_compare #(.WAYS(WAYS), .ATAG_W(ATAG_W)) u_dir (
    .lookup_en(lookup_en),
    .abs_tag  (abs_tag),
    .dir_valid(dir_valid),
    .dir_tag  (dir_tag),
    .way_match(way_match)
  );

  chu_way_select #(.WAYS(WAYS), .DATA_W(DATA_W)) u_sel (
    .way_match (way_match),
    .way_data  (way_data),
    .sel_onehot(sel_onehot),
    .any_hit   (lookup_hit),
    .multi     (lookup_multi),
    .sel_data  (sel_data)
  );

  // verdict registers reload every edge: one-cycle lifetime
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      way_q  <= '0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      hit_q <= lookup_hit;
      way_q <= sel_onehot;
      err_q <= lookup_multi;
      if (lookup_hit) data_q <= sel_data;
    end
  end

  assign hit       = hit_q;
  assign hit_way   = way_q;
  assign multi_hit = err_q;
  assign data_out  = data_q;

  assert_way_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> ($countones(way_q) == 1));
  assert_miss_way_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_q |-> (way_q == '0));
  assert_idle_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!hit_q && !err_q));
  assert_miss_holds_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_hit |=> $stable(data_q));
  assert_err_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> hit_q);
  assert_pick_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |-> (((sel_onehot & way_match) == sel_onehot) &&
                    (((sel_onehot - 1'b1) & way_match) == '0)));
  assert_valid_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (way_match & ~dir_valid) == '0);
endmodule

// File: tb/cache_hit_unit_bench.sv
module cache_hit_unit_bench;
  localparam int TLB_N = 2, VW = 8, AW = 10, WAYS = 4, DW = 32, SETS = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [VW-1:0] req_vtag = '0;
  logic [TLB_N-1:0] ltlb_valid = '0;
  logic [WAYS-1:0] dir_valid = '0;
  logic [VW-1:0] d_lv [TLB_N];
  logic [AW-1:0] d_ap [TLB_N];
  logic [AW-1:0] d_dt [WAYS];
  logic [DW-1:0] d_wd [WAYS];
  logic [TLB_N*VW-1:0] ltlb_vtag;
  logic [TLB_N*AW-1:0] atlb_page;
  logic [WAYS*AW-1:0] dir_tag;
  logic [WAYS*DW-1:0] way_data;
  logic hit, multi_hit;
  logic [WAYS-1:0] hit_way;
  logic [DW-1:0] data_out;

  // bench register files, one row per set
  logic [TLB_N-1:0] rf_lval [SETS];
  logic [VW-1:0] rf_lv [SETS][TLB_N];
  logic [AW-1:0] rf_ap [SETS][TLB_N];
  logic [WAYS-1:0] rf_dval [SETS];
  logic [AW-1:0] rf_dt [SETS][WAYS];
  logic [DW-1:0] rf_wd [SETS][WAYS];

  int checks = 0, failures = 0, cyc = 0;
  bit exp_hit = 0, exp_err = 0;
  logic [WAYS-1:0] exp_way = '0;
  logic [DW-1:0] exp_data = '0;

  for (genvar i = 0; i < TLB_N; i++) begin : g_t
    assign ltlb_vtag[i*VW +: VW] = d_lv[i];
    assign atlb_page[i*AW +: AW] = d_ap[i];
  end
  for (genvar i = 0; i < WAYS; i++) begin : g_w
    assign dir_tag[i*AW +: AW] = d_dt[i];
    assign way_data[i*DW +: DW] = d_wd[i];
  end

  cache_hit_unit #(.TLB_N(TLB_N), .VTAG_W(VW), .ATAG_W(AW), .WAYS(WAYS), .DATA_W(DW)) u_cache_hit_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vtag(req_vtag),
    .ltlb_valid(ltlb_valid), .ltlb_vtag(ltlb_vtag), .atlb_page(atlb_page),
    .dir_valid(dir_valid), .dir_tag(dir_tag), .way_data(way_data),
    .hit(hit), .hit_way(hit_way), .multi_hit(multi_hit), .data_out(data_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // write port into the bench register files
  task automatic write_row(int s, logic [TLB_N-1:0] lval, logic [WAYS-1:0] dval);
    rf_lval[s] = lval;
    rf_dval[s] = dval;
  endtask

  task automatic present(int s, bit rq, logic [VW-1:0] vt);
    req_valid = rq; req_vtag = vt;
    ltlb_valid = rf_lval[s]; dir_valid = rf_dval[s];
    for (int i = 0; i < TLB_N; i++) begin d_lv[i] = rf_lv[s][i]; d_ap[i] = rf_ap[s][i]; end
    for (int i = 0; i < WAYS; i++) begin d_dt[i] = rf_dt[s][i]; d_wd[i] = rf_wd[s][i]; end
  endtask

  // behavioural reference, then one clock, then compare
  task automatic cycle(string tag);
    int t_sel = -1, nmatch = 0, first = -1;
    for (int i = TLB_N - 1; i >= 0; i--)
      if (ltlb_valid[i] && d_lv[i] == req_vtag) t_sel = i;
    if (req_valid && t_sel >= 0)
      for (int w = 0; w < WAYS; w++)
        if (dir_valid[w] && d_dt[w] == d_ap[t_sel]) begin
          nmatch++;
          if (first < 0) first = w;
        end
    exp_hit = nmatch > 0;
    exp_err = nmatch > 1;
    exp_way = exp_hit ? WAYS'(1 << first) : '0;
    if (exp_hit) exp_data = d_wd[first];
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk(req_valid ? (exp_hit ? "R2" : "R5") : "R10", {tag, " hit"}, 64'(hit), 64'(exp_hit));
    chk("R3", {tag, " hit_way"}, 64'(hit_way), 64'(exp_way));
    chk(exp_hit ? "R4" : "R5", {tag, " data_out"}, 64'(data_out), 64'(exp_data));
    chk("R7", {tag, " multi_hit"}, 64'(multi_hit), 64'(exp_err));
  endtask

  task automatic clear_row(int s);
    for (int i = 0; i < TLB_N; i++) begin rf_lv[s][i] = 8'hF0 + 8'(i); rf_ap[s][i] = 10'h3F0 + 10'(i); end
    for (int w = 0; w < WAYS; w++) begin rf_dt[s][w] = 10'h100 + 10'(w); rf_wd[s][w] = 32'hD000_0000 + 32'(w); end
    write_row(s, '0, '0);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) clear_row(s);
    present(0, 0, '0);
    repeat (3) @(negedge clk);
    chk("R1", "reset hit", 64'(hit), 0);
    chk("R1", "reset hit_way", 64'(hit_way), 0);
    chk("R1", "reset multi_hit", 64'(multi_hit), 0);
    chk("R1", "reset data_out", 64'(data_out), 0);
    rst_n = 1'b1;

    // single translated hit on way 2
    rf_lv[0][0] = 8'h05; rf_ap[0][0] = 10'h064;
    rf_dt[0][2] = 10'h064; rf_wd[0][2] = 32'hCAFE_0002;
    write_row(0, 2'b01, 4'b1111);
    present(0, 1, 8'h05); cycle("R2 basic");
    chk("R4", "way2 word", 64'(data_out), 64'h0000_0000_CAFE_0002);
    // idle after hit: hit gone, data kept
    present(0, 0, 8'h05); cycle("R9 idle");
    chk("R9", "hit after idle", 64'(hit), 0);
    chk("R5", "data kept", 64'(data_out), 64'h0000_0000_CAFE_0002);
    // invalid directory way
    write_row(0, 2'b01, 4'b1011);
    present(0, 1, 8'h05); cycle("R6 dir invalid");
    chk("R6", "dir invalid miss", 64'(hit), 0);
    // invalid TLB entry
    write_row(0, 2'b00, 4'b1111);
    present(0, 1, 8'h05); cycle("R6 tlb invalid");
    chk("R6", "tlb invalid miss", 64'(hit), 0);
    // two TLB entries alias: lowest entry's page wins
    clear_row(1);
    rf_lv[1][0] = 8'h07; rf_ap[1][0] = 10'h0C8;
    rf_lv[1][1] = 8'h07; rf_ap[1][1] = 10'h064;
    rf_dt[1][1] = 10'h064; rf_dt[1][3] = 10'h0C8; rf_wd[1][3] = 32'hBEEF_0003;
    write_row(1, 2'b11, 4'b1111);
    present(1, 1, 8'h07); cycle("R8 alias");
    chk("R8", "alias way", 64'(hit_way), 64'b1000);
    // two ways carry the same tag
    clear_row(2);
    rf_lv[2][1] = 8'h09; rf_ap[2][1] = 10'h055;
    rf_dt[2][0] = 10'h055; rf_dt[2][3] = 10'h055; rf_wd[2][0] = 32'h1111_0000;
    write_row(2, 2'b10, 4'b1001);
    present(2, 1, 8'h09); cycle("R7 multi");
    chk("R7", "multi flag", 64'(multi_hit), 1);
    chk("R7", "lowest way", 64'(hit_way), 64'b0001);

    // random traffic over loaded register files
    for (int s = 0; s < SETS; s++) begin
      for (int i = 0; i < TLB_N; i++) begin rf_lv[s][i] = 8'($urandom_range(0, 3)); rf_ap[s][i] = 10'($urandom_range(0, 3)); end
      for (int w = 0; w < WAYS; w++) begin rf_dt[s][w] = 10'($urandom_range(0, 5)); rf_wd[s][w] = $urandom; end
      write_row(s, TLB_N'($urandom), WAYS'($urandom));
    end
    for (int n = 0; n < 400; n++) begin
      present($urandom_range(0, SETS - 1), $urandom_range(0, 3) != 0, 8'($urandom_range(0, 3)));
      cycle("random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule